// File: doc/BRIEF.md
# Narrow-Access Register Write Coalescer

This block sits between a host that issues byte, half-word and word register accesses and a register file that only understands aligned 32-bit reads and writes. Every narrow write is turned into a read of the containing dword, a lane merge and a full-dword write back. Narrow reads fetch the containing dword and return the addressed lane in the low bits.

Four half-word registers get special treatment: the transfer-mode, block-size and block-count halves, and the command half. The command half shares a dword with transfer mode, and the two block halves share another. Writes to transfer mode or to the block halves are held in two shadow words and are not sent downstream. When the command half is written, any pending block shadow is written out first as one dword. The command half is then merged into the command shadow and written as one dword. As a result, the partner half-word in each pair is never overwritten by a stale read.

The upstream port takes one request at a time. The request is held until a one-cycle acknowledge. The downstream port raises a request and holds it, with address and data stable, until the register file returns a one-cycle acknowledge.

Top module: `regcoal_top`

## Requirements
- R1: Every downstream access is a full 32-bit access at the request address with its two low bits forced to zero.
- R2: The size code is 0 for byte, 1 for half-word and 2 or 3 for word. A narrow read returns the addressed lane shifted down to bit 0, with the upper bits zero. The lane sits at bit position 8 times the two low address bits, with a mask of 0xFF for a byte or 0xFFFF for a half.
- R3: A byte write, or a half write to any address other than the four special halves, reads the aligned dword and replaces only the addressed lane. It then writes the result back as one downstream write.
- R4: A half write to transfer mode (0x0C) reads dword 0x0C and merges the new half into the command shadow word. It makes no downstream write and sets the command-pending flag.
- R5: A half write to block size (0x04) or block count (0x06) merges into the block shadow word and makes no downstream write. The old value is the shadow word if the block-pending flag is already set; otherwise it is read from dword 0x04. The flag is then set.
- R6: A half write to the command register (0x0E) first writes the block shadow to dword 0x04 if block-pending is set, and clears that flag. It then merges the command half into the command shadow word, writes the result to dword 0x0C, and clears command-pending.
- R7: A half read of 0x0C returns the command shadow half while command-pending is set. A half read of 0x04 or 0x06 returns the block shadow half while block-pending is set. In those cases no downstream access is made; otherwise the read goes downstream.
- R8: Word reads and writes pass straight to the aligned dword and leave the shadows untouched.
- R9: After reset both shadow words and both flags are zero. A command write with no prior transfer-mode write therefore stores zero in the transfer-mode half.
- R10: Requests are served one at a time. The upstream acknowledge is a single-cycle pulse given only after the last downstream access of the request completes. A downstream request holds its address, direction and data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Host request, held until up_ack |
| up_we | input | 1 | Host write (1) or read (0) |
| up_addr | input | AW | Host byte address |
| up_size | input | 2 | Access size code (0 byte, 1 half, 2/3 word) |
| up_wdata | input | 32 | Host write data, right-aligned |
| up_ack | output | 1 | One-cycle completion pulse |
| up_rdata | output | 32 | Read result, valid with up_ack |
| dn_req | output | 1 | Downstream request, held until dn_ack |
| dn_we | output | 1 | Downstream write (1) or read (0) |
| dn_addr | output | AW | Downstream dword-aligned address |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream one-cycle completion |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |

## Verification
The bench builds the block with its defaults: an 8-bit address and the four special halves at 0x04, 0x06, 0x0C and 0x0E. The random addresses are confined to the first sixteen dwords and biased toward dwords 1 and 3. That lets random sequences of size, count, transfer-mode and command writes interleave with ordinary lane traffic. It also reaches states such as a second block write merging into a pending shadow, reads of pending shadows, and command writes with and without a pending block flush. The downstream model answers after a random 0 to 2 cycle delay, so the hold-until-acknowledge behaviour is exercised on every access.

// File: rtl/regcoal_pkg.sv
package regcoal_pkg;

  localparam int DW = 32;

  typedef enum logic [3:0] {
    OP_RD_WORD, OP_RD_LANE, OP_RD_TM, OP_RD_BLK,
    OP_WR_WORD, OP_WR_RMW, OP_WR_TM, OP_WR_BLK, OP_WR_CMD
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_FLUSH, S_WR, S_ACK
  } st_e;

  function automatic logic [4:0] lane_shift(input logic [1:0] lo);
    return {lo, 3'b000};
  endfunction

  function automatic logic [DW-1:0] lane_width_mask(input logic half);
    return half ? 32'h0000_FFFF : 32'h0000_00FF;
  endfunction

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old,
                                               input logic [DW-1:0] data,
                                               input logic [1:0] lo,
                                               input logic half);
    logic [DW-1:0] m;
    m = lane_width_mask(half);
    return (old & ~(m << lane_shift(lo))) | ((data & m) << lane_shift(lo));
  endfunction

  function automatic logic [DW-1:0] lane_extract(input logic [DW-1:0] word,
                                                 input logic [1:0] lo,
                                                 input logic half);
    return (word >> lane_shift(lo)) & lane_width_mask(half);
  endfunction

endpackage

// File: rtl/regcoal_decode.sv
module regcoal_decode
  import regcoal_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] BLK_SIZE_OFS  = 'h04,
  parameter logic [AW-1:0] BLK_CNT_OFS   = 'h06,
  parameter logic [AW-1:0] XFER_MODE_OFS = 'h0C,
  parameter logic [AW-1:0] CMD_OFS       = 'h0E
) (
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output op_e           op
);

  logic is_half, is_word, hit_tm, hit_blk, hit_cmd;

  always_comb begin
    is_half = (size == 2'd1);
    is_word = size[1];
    hit_tm  = (addr == XFER_MODE_OFS);
    hit_blk = (addr == BLK_SIZE_OFS) || (addr == BLK_CNT_OFS);
    hit_cmd = (addr == CMD_OFS);
    if (is_word)               op = we ? OP_WR_WORD : OP_RD_WORD;
    else if (is_half && we) begin
      if (hit_tm)              op = OP_WR_TM;
      else if (hit_blk)        op = OP_WR_BLK;
      else if (hit_cmd)        op = OP_WR_CMD;
      else                     op = OP_WR_RMW;
    end else if (is_half) begin
      if (hit_tm)              op = OP_RD_TM;
      else if (hit_blk)        op = OP_RD_BLK;
      else                     op = OP_RD_LANE;
    end else                   op = we ? OP_WR_RMW : OP_RD_LANE;
  end

endmodule

// File: rtl/regcoal_shadow.sv
module regcoal_shadow
  import regcoal_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_load,
  input  logic [DW-1:0] cmd_val,
  input  logic          cmd_clr,
  input  logic          blk_load,
  input  logic [DW-1:0] blk_val,
  input  logic          blk_clr,
  output logic [DW-1:0] cmd_word,
  output logic          cmd_pend,
  output logic [DW-1:0] blk_word,
  output logic          blk_pend
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_word <= '0;
      cmd_pend <= 1'b0;
      blk_word <= '0;
      blk_pend <= 1'b0;
    end else begin
      if (cmd_load) begin
        cmd_word <= cmd_val;
        cmd_pend <= 1'b1;
      end else if (cmd_clr) begin
        cmd_pend <= 1'b0;
      end
      if (blk_load) begin
        blk_word <= blk_val;
        blk_pend <= 1'b1;
      end else if (blk_clr) begin
        blk_pend <= 1'b0;
      end
    end
  end

  // R4: a transfer-mode store leaves the command shadow pending with the merged word
  a_r4_tm_store_pends: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |=> cmd_pend && cmd_word == $past(cmd_val));
  // R5: a block store leaves the block shadow pending with the merged word
  a_r5_blk_store_pends: assert property (@(posedge clk) disable iff (!rst_n)
    blk_load |=> blk_pend && blk_word == $past(blk_val));
  // R6: issuing a command retires the command shadow, flushing retires the block shadow
  a_r6_cmd_retires: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> !cmd_pend);
  a_r6_flush_retires: assert property (@(posedge clk) disable iff (!rst_n)
    blk_clr |=> !blk_pend);
  // R6: a flush never coincides with a new store into the same shadow
  a_r6_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_load && blk_clr) && !(cmd_load && cmd_clr));

endmodule

// File: rtl/regcoal_seq.sv
module regcoal_seq
  import regcoal_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] BLK_SIZE_OFS = 'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_req,
  input  logic [AW-1:0] up_addr,
  input  logic [1:0]    up_size,
  input  logic [DW-1:0] up_wdata,
  input  op_e           op_in,
  output logic          up_ack,
  output logic [DW-1:0] up_rdata,
  output logic          dn_req,
  output logic          dn_we,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_ack,
  input  logic [DW-1:0] dn_rdata,
  input  logic [DW-1:0] cmd_word,
  input  logic          cmd_pend,
  input  logic [DW-1:0] blk_word,
  input  logic          blk_pend,
  output logic          cmd_load,
  output logic [DW-1:0] cmd_val,
  output logic          cmd_clr,
  output logic          blk_load,
  output logic [DW-1:0] blk_val,
  output logic          blk_clr
);

  localparam logic [AW-1:0] BLK_DW_ADDR = {BLK_SIZE_OFS[AW-1:2], 2'b00};

  st_e           st;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic          half_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] data_q;

  // named internal events
  logic ev_accept, ev_dn_done, in_idle;
  assign in_idle    = (st == S_IDLE);
  assign ev_accept  = in_idle && up_req;
  assign ev_dn_done = dn_req && dn_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_RD_WORD;
      addr_q  <= '0;
      half_q  <= 1'b0;
      wdata_q <= '0;
      data_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (up_req) begin
          op_q    <= op_in;
          addr_q  <= up_addr;
          half_q  <= (up_size == 2'd1);
          wdata_q <= up_wdata;
          case (op_in)
            OP_WR_WORD: begin
              data_q <= up_wdata;
              st     <= S_WR;
            end
            OP_RD_TM: if (cmd_pend) begin
              data_q <= lane_extract(cmd_word, up_addr[1:0], 1'b1);
              st     <= S_ACK;
            end else st <= S_RD;
            OP_RD_BLK: if (blk_pend) begin
              data_q <= lane_extract(blk_word, up_addr[1:0], 1'b1);
              st     <= S_ACK;
            end else st <= S_RD;
            OP_WR_BLK: st <= blk_pend ? S_ACK : S_RD;
            OP_WR_CMD: begin
              data_q <= lane_merge(cmd_word, up_wdata, up_addr[1:0], 1'b1);
              st     <= blk_pend ? S_FLUSH : S_WR;
            end
            default: st <= S_RD;
          endcase
        end
        S_RD: if (dn_ack) begin
          case (op_q)
            OP_RD_WORD: begin
              data_q <= dn_rdata;
              st     <= S_ACK;
            end
            OP_WR_RMW: begin
              data_q <= lane_merge(dn_rdata, wdata_q, addr_q[1:0], half_q);
              st     <= S_WR;
            end
            OP_WR_TM, OP_WR_BLK: st <= S_ACK;
            default: begin
              data_q <= lane_extract(dn_rdata, addr_q[1:0], half_q);
              st     <= S_ACK;
            end
          endcase
        end
        S_FLUSH: if (dn_ack) st <= S_WR;
        S_WR:    if (dn_ack) st <= S_ACK;
        S_ACK:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // shadow control
  always_comb begin
    blk_load = (ev_accept && op_in == OP_WR_BLK && blk_pend) ||
               (st == S_RD && dn_ack && op_q == OP_WR_BLK);
    blk_val  = lane_merge(in_idle ? blk_word : dn_rdata,
                          in_idle ? up_wdata : wdata_q,
                          in_idle ? up_addr[1:0] : addr_q[1:0], 1'b1);
    cmd_load = (st == S_RD) && dn_ack && (op_q == OP_WR_TM);
    cmd_val  = lane_merge(dn_rdata, wdata_q, addr_q[1:0], 1'b1);
    blk_clr  = (st == S_FLUSH) && dn_ack;
    cmd_clr  = (st == S_WR) && dn_ack && (op_q == OP_WR_CMD);
  end

  // ports
  always_comb begin
    dn_req   = (st == S_RD) || (st == S_FLUSH) || (st == S_WR);
    dn_we    = (st != S_RD);
    dn_addr  = (st == S_FLUSH) ? BLK_DW_ADDR : {addr_q[AW-1:2], 2'b00};
    dn_wdata = (st == S_FLUSH) ? blk_word : data_q;
    up_ack   = (st == S_ACK);
    up_rdata = data_q;
  end

  // R10: the upstream acknowledge is a single-cycle pulse
  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack |=> !up_ack);
  // R10: a downstream request holds steady until acknowledged
  a_r10_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata));
  // R10: no new request is taken while a downstream access is outstanding
  a_r10_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> !ev_accept);
  // R6: the command dword is written only after any pending block flush
  a_r6_flush_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && op_q == OP_WR_CMD) |-> !blk_pend);
  // R4, R5: deferred half writes never reach the register file as writes
  a_r4_r5_no_dn_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_we) |-> (op_q != OP_WR_TM && op_q != OP_WR_BLK));
  // R7: a pending shadow is read without a downstream access
  a_r7_shadow_read_local: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD) |-> !((op_q == OP_RD_TM && cmd_pend) || (op_q == OP_RD_BLK && blk_pend)));
  // R1: downstream address is dword aligned
  a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> dn_addr[1:0] == 2'b00);

endmodule

// File: rtl/regcoal_top.sv
module regcoal_top
  import regcoal_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] BLK_SIZE_OFS  = 'h04,
  parameter logic [AW-1:0] BLK_CNT_OFS   = 'h06,
  parameter logic [AW-1:0] XFER_MODE_OFS = 'h0C,
  parameter logic [AW-1:0] CMD_OFS       = 'h0E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_req,
  input  logic          up_we,
  input  logic [AW-1:0] up_addr,
  input  logic [1:0]    up_size,
  input  logic [31:0]   up_wdata,
  output logic          up_ack,
  output logic [31:0]   up_rdata,
  output logic          dn_req,
  output logic          dn_we,
  output logic [AW-1:0] dn_addr,
  output logic [31:0]   dn_wdata,
  input  logic          dn_ack,
  input  logic [31:0]   dn_rdata
);

  op_e           op_in;
  logic [DW-1:0] cmd_word, blk_word, cmd_val, blk_val;
  logic          cmd_pend, blk_pend, cmd_load, cmd_clr, blk_load, blk_clr;

  regcoal_decode #(
    .AW(AW), .BLK_SIZE_OFS(BLK_SIZE_OFS), .BLK_CNT_OFS(BLK_CNT_OFS),
    .XFER_MODE_OFS(XFER_MODE_OFS), .CMD_OFS(CMD_OFS)
  ) u_decode (
    .we(up_we), .addr(up_addr), .size(up_size), .op(op_in)
  );

  regcoal_shadow u_shadow (
    .clk(clk), .rst_n(rst_n),
    .cmd_load(cmd_load), .cmd_val(cmd_val), .cmd_clr(cmd_clr),
    .blk_load(blk_load), .blk_val(blk_val), .blk_clr(blk_clr),
    .cmd_word(cmd_word), .cmd_pend(cmd_pend),
    .blk_word(blk_word), .blk_pend(blk_pend)
  );

  regcoal_seq #(.AW(AW), .BLK_SIZE_OFS(BLK_SIZE_OFS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .up_req(up_req), .up_addr(up_addr), .up_size(up_size), .up_wdata(up_wdata),
    .op_in(op_in), .up_ack(up_ack), .up_rdata(up_rdata),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_ack(dn_ack), .dn_rdata(dn_rdata),
    .cmd_word(cmd_word), .cmd_pend(cmd_pend), .blk_word(blk_word), .blk_pend(blk_pend),
    .cmd_load(cmd_load), .cmd_val(cmd_val), .cmd_clr(cmd_clr),
    .blk_load(blk_load), .blk_val(blk_val), .blk_clr(blk_clr)
  );

  // R9: the shadows start out empty after reset
  a_r9_reset_empty: assert property (@(posedge clk)
    $rose(rst_n) |-> !cmd_pend && !blk_pend && cmd_word == '0 && blk_word == '0);

endmodule

// File: tb/regcoal_top_bench.sv
module regcoal_top_bench;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req = 1'b0, up_we = 1'b0;
  logic [AW-1:0] up_addr = '0;
  logic [1:0] up_size = '0;
  logic [31:0] up_wdata = '0;
  logic up_ack, dn_req, dn_we;
  logic [31:0] up_rdata, dn_wdata;
  logic [AW-1:0] dn_addr;
  logic dn_ack;
  logic [31:0] dn_rdata;

  always #4 clk = ~clk;

  regcoal_top #(.AW(AW)) u_regcoal_top (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_we(up_we), .up_addr(up_addr),
    .up_size(up_size), .up_wdata(up_wdata), .up_ack(up_ack), .up_rdata(up_rdata),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_ack(dn_ack), .dn_rdata(dn_rdata)
  );

  int total = 0, bad = 0;

  function automatic logic [31:0] seed_word(input int i);
    return (i * 32'h9E37_79B1) ^ 32'h5A5A_A5A5;
  endfunction

  // downstream register file model with random latency
  logic [31:0] mem [0:63];
  int wr_cnt, misalign;
  int lat;
  always @(posedge clk) begin
    if (!rst_n) begin
      dn_ack <= 1'b0; dn_rdata <= '0; lat <= 0; wr_cnt <= 0; misalign <= 0;
      for (int i = 0; i < 64; i++) mem[i] <= seed_word(i);
    end else if (dn_ack) begin
      dn_ack <= 1'b0;
    end else if (dn_req) begin
      if (lat == 0) begin
        dn_ack   <= 1'b1;
        dn_rdata <= mem[dn_addr[7:2]];
        if (dn_we) begin
          mem[dn_addr[7:2]] <= dn_wdata;
          wr_cnt <= wr_cnt + 1;
        end
        if (dn_addr[1:0] != 2'b00) misalign <= misalign + 1;
        lat <= int'($urandom % 3);
      end else lat <= lat - 1;
    end
  end

  // reference state
  logic [31:0] exp_mem [0:63];
  logic [31:0] s_cmd, s_blk;
  logic p_cmd, p_blk;

  function automatic logic [31:0] put_lane(input logic [31:0] old, input logic [1:0] lo,
                                           input logic half, input logic [31:0] d);
    logic [31:0] r;
    r = old;
    if (half) begin
      if (lo[1]) r[31:16] = d[15:0]; else r[15:0] = d[15:0];
    end else begin
      case (lo)
        2'd0: r[7:0]   = d[7:0];
        2'd1: r[15:8]  = d[7:0];
        2'd2: r[23:16] = d[7:0];
        default: r[31:24] = d[7:0];
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] get_lane(input logic [31:0] w, input logic [1:0] lo,
                                           input logic half);
    if (half) return lo[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    case (lo)
      2'd0: return {24'h0, w[7:0]};
      2'd1: return {24'h0, w[15:8]};
      2'd2: return {24'h0, w[23:16]};
      default: return {24'h0, w[31:24]};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic ref_op(input logic we, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output int w,
                        output string tag);
    logic half, tm, blk, cmd;
    int dw;
    dw = int'(a[7:2]);
    half = (sz == 2'd1);
    tm = (a == 8'h0C); blk = (a == 8'h04 || a == 8'h06); cmd = (a == 8'h0E);
    rd = '0; w = 0;
    if (sz[1]) begin
      tag = "R8";
      if (we) begin exp_mem[dw] = wd; w = 1; end
      else rd = exp_mem[dw];
    end else if (half && we && tm) begin
      tag = "R4"; s_cmd = put_lane(exp_mem[dw], a[1:0], 1'b1, wd); p_cmd = 1'b1;
    end else if (half && we && blk) begin
      tag = "R5"; s_blk = put_lane(p_blk ? s_blk : exp_mem[dw], a[1:0], 1'b1, wd); p_blk = 1'b1;
    end else if (half && we && cmd) begin
      tag = "R6";
      if (p_blk) begin exp_mem[1] = s_blk; p_blk = 1'b0; w = 1; end
      exp_mem[3] = put_lane(s_cmd, a[1:0], 1'b1, wd); p_cmd = 1'b0; w = w + 1;
    end else if (we) begin
      tag = "R3"; exp_mem[dw] = put_lane(exp_mem[dw], a[1:0], half, wd); w = 1;
    end else if (half && tm && p_cmd) begin
      tag = "R7"; rd = get_lane(s_cmd, a[1:0], 1'b1);
    end else if (half && blk && p_blk) begin
      tag = "R7"; rd = get_lane(s_blk, a[1:0], 1'b1);
    end else begin
      tag = "R2"; rd = get_lane(exp_mem[dw], a[1:0], half);
    end
  endtask

  task automatic do_op(input logic we, input logic [7:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd);
    logic [31:0] erd;
    int ew, c0, mism;
    string tag;
    ref_op(we, a, sz, wd, erd, ew, tag);
    c0 = wr_cnt;
    @(negedge clk);
    up_req = 1'b1; up_we = we; up_addr = a; up_size = sz; up_wdata = wd;
    do @(negedge clk); while (!up_ack);
    rd = up_rdata;
    up_req = 1'b0;
    if (!we) chk({tag, " read data"}, rd, erd);
    chk({tag, " downstream writes"}, 32'(wr_cnt - c0), 32'(ew));
    mism = 0;
    for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) mism++;
    chk({tag, " register file image"}, 32'(mism), 32'd0);
    @(negedge clk);
    chk("R10 ack is one cycle", {31'd0, up_ack}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic [7:0] a;
    logic [1:0] sz;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) exp_mem[i] = seed_word(i);
    s_cmd = '0; s_blk = '0; p_cmd = 1'b0; p_blk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset ack idle", {31'd0, up_ack}, 32'd0);
    chk("R9 reset dn idle", {31'd0, dn_req}, 32'd0);

    // R9: command with empty transfer-mode shadow
    do_op(1'b1, 8'h0E, 2'd1, 32'h0000_A5C3, rd);
    chk("R9 command dword after reset", mem[3], 32'hA5C3_0000);
    // R4 then R7
    do_op(1'b1, 8'h0C, 2'd1, 32'h0000_1234, rd);
    do_op(1'b0, 8'h0C, 2'd2, 32'h0, rd);
    chk("R4 transfer mode not written", rd, 32'hA5C3_0000);
    do_op(1'b0, 8'h0C, 2'd1, 32'h0, rd);
    chk("R7 transfer mode from shadow", rd, 32'h0000_1234);
    // R5 then R7
    do_op(1'b1, 8'h04, 2'd1, 32'h0000_0200, rd);
    do_op(1'b1, 8'h06, 2'd1, 32'h0000_0008, rd);
    do_op(1'b0, 8'h06, 2'd1, 32'h0, rd);
    chk("R7 block count from shadow", rd, 32'h0000_0008);
    do_op(1'b0, 8'h04, 2'd2, 32'h0, rd);
    chk("R5 block dword untouched", rd, seed_word(1));
    // R6: flush then command
    do_op(1'b1, 8'h0E, 2'd1, 32'h0000_113A, rd);
    chk("R6 block flushed", mem[1], 32'h0008_0200);
    chk("R6 command merged", mem[3], 32'h113A_1234);
    // R3 byte lane
    do_op(1'b1, 8'h23, 2'd0, 32'hFFFF_FF5E, rd);
    chk("R3 byte lane merged", mem[8], {8'h5E, seed_word(8)[23:0]});

    for (int n = 0; n < 600; n++) begin
      if ($urandom % 2 == 0) a = {2'b00, ($urandom % 2 == 0) ? 4'd1 : 4'd3, 2'($urandom)};
      else a = {2'b00, 4'($urandom), 2'($urandom)};
      sz = 2'($urandom % 3);
      if (sz == 2'd1) a[0] = 1'b0;
      if (sz == 2'd2) a[1:0] = 2'b00;
      do_op(1'($urandom), a, sz, $urandom, rd);
    end

    chk("R1 misaligned downstream accesses", 32'(misalign), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule